// File: doc/BRIEF.md
# I2C Byte-Memory Read Slave

This block is the bus-facing half of a small byte memory that sits on a two-wire I2C bus. It samples SCL and SDA with the system clock and recognises START, repeated START and STOP. It answers to one 7-bit device address. When the address byte has the read/write bit clear, it accepts a two-byte word address into a 9-bit read pointer. When the read/write bit is set, it shifts bytes out from that pointer. SDA is never driven high: the block only asserts an enable that pulls the line low.

Four kinds of transaction are served:
- A random read is a dummy write of the word address, then a repeated START and a read-direction address.
- A pointer-only transaction is the same dummy write closed by STOP. It moves the pointer and transfers no data.
- A current-address read starts from wherever the pointer was left.
- A sequential read keeps sending bytes for as long as the master acknowledges. The pointer runs through the whole array and wraps to zero.

Array contents are loaded through a plain synchronous write port beside the bus logic.

Top module: `i2c_byte_mem_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and the read pointer is 0, so the first current-address read returns location 0.
- R2: SDA falling while SCL is high is a START (or repeated START). From any state it restarts byte reception at bit 0 and releases SDA. SDA rising while SCL is high is a STOP and returns the block to idle.
- R3: The first byte after a START is compared MSB first: bits 7..1 against parameter `DEV_ADDR`, bit 0 is the direction (1 = read). On a match the block pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores all bits until the next START, with the pointer unchanged.
- R4: After a write-direction match, two word-address bytes follow, high byte first, and each is acknowledged. The pointer becomes {bit 0 of the high byte, low byte}, and bits 7..1 of the high byte are ignored.
- R5: A STOP right after the second word-address acknowledge leaves the new pointer in place with no data sent. The next current-address read returns that location.
- R6: A read-direction match is acknowledged. Then the byte at the pointer is sent MSB first, one bit per SCL low phase.
- R7: Each master acknowledge (SDA low on the ninth clock) after a data byte causes the byte from pointer n+1 to follow the byte from n.
- R8: The pointer advances from 511 to 0 and the read continues.
- R9: A master not-acknowledge ends the read. SDA stays released through any further SCL activity until START or STOP. The pointer rests one past the last byte sent.
- R10: `sda_oe` changes only while SCL is low, apart from the release that follows a START or STOP.
- R11: With `wr_en` high at a clock edge, `wr_data` is stored at `wr_addr`, and later bus reads of that location return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en | input | 1 | Side-port write strobe |
| wr_addr | input | 9 | Side-port write location |
| wr_data | input | 8 | Side-port write byte |

## Verification
The assertions assume a well-behaved master. It never issues START or STOP while the slave is pulling SDA low. It holds each SCL phase for several system clocks, so the two-stage synchronisers keep the order of SCL and SDA changes. The bench's master task changes SDA two clocks into each SCL low phase and gives every phase at least six clocks. It always sends a not-acknowledge on the last byte before STOP or a new START, so the slave is never driving at a bus condition.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  // protocol phase of the slave
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK,
    PH_IGNORE
  } phase_t;

  // which received byte is in the shifter
  typedef enum logic [1:0] {
    BK_DEV,
    BK_HI,
    BK_LO
  } bytekind_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_q  <= scl_sh[SYNC-1];
      sda_q  <= sda_sh[SYNC-1];
    end
  end

  assign scl_lvl   = scl_sh[SYNC-1];
  assign sda_lvl   = sda_sh[SYNC-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  // data edges while the clock stays high mark bus conditions
  assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_ptr_counter.sv
module i2c_ptr_counter #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);
  // next location, wrapping over the whole array
  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] p);
    return p + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= step(ptr);
  end
endmodule

// File: rtl/i2c_byte_store.sv
module i2c_byte_store #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/i2c_byte_mem_slave.sv
module i2c_byte_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int          ADDR_W   = 9,
  parameter logic [6:0]  DEV_ADDR = 7'h57,
  parameter int          SYNC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data
);
  localparam int HI_W = ADDR_W - BYTE_W;

  // events brought out for the checker
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, evt_start, evt_stop;
  logic bus_quiet, dev_miss, ptr_load, ptr_inc;
  logic [ADDR_W-1:0] ptr, ptr_load_val;
  logic [7:0] rd_data;

  phase_t    phase;
  bytekind_t kind;
  logic [2:0] bitcnt;
  logic       full, to_tx, acked;
  logic [7:0] rx_sr, tx_sr;
  logic [HI_W-1:0] hi_keep;

  i2c_line_sampler #(.SYNC(SYNC)) u_samp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(evt_start), .stop_evt(evt_stop)
  );

  i2c_ptr_counter #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_load_val),
    .inc(ptr_inc), .ptr(ptr)
  );

  i2c_byte_store #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data)
  );

  // address byte carries the 7-bit device id above the direction bit
  function automatic logic id_match(input logic [7:0] b);
    return b[7:1] == DEV_ADDR;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      kind         <= BK_DEV;
      bitcnt       <= '0;
      full         <= 1'b0;
      to_tx        <= 1'b0;
      acked        <= 1'b0;
      rx_sr        <= '0;
      tx_sr        <= '1;
      hi_keep      <= '0;
      ptr_load_val <= '0;
      ptr_load     <= 1'b0;
      ptr_inc      <= 1'b0;
      dev_miss     <= 1'b0;
    end else begin
      ptr_load <= 1'b0;
      ptr_inc  <= 1'b0;
      dev_miss <= 1'b0;
      if (evt_start) begin
        phase  <= PH_RX;
        kind   <= BK_DEV;
        bitcnt <= '0;
        full   <= 1'b0;
      end else if (evt_stop) begin
        phase <= PH_IDLE;
      end else begin
        unique case (phase)
          PH_RX: begin
            if (scl_rise && !full) begin
              rx_sr  <= {rx_sr[6:0], sda_lvl};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) full <= 1'b1;
            end else if (scl_fall && full) begin
              full   <= 1'b0;
              bitcnt <= '0;
              to_tx  <= 1'b0;
              unique case (kind)
                BK_DEV: begin
                  if (id_match(rx_sr)) begin
                    phase <= PH_RX_ACK;
                    to_tx <= rx_sr[0];
                  end else begin
                    phase    <= PH_IGNORE;
                    dev_miss <= 1'b1;
                  end
                end
                BK_HI: begin
                  hi_keep <= rx_sr[HI_W-1:0];
                  phase   <= PH_RX_ACK;
                end
                default: begin
                  ptr_load_val <= {hi_keep, rx_sr};
                  ptr_load     <= 1'b1;
                  phase        <= PH_RX_ACK;
                end
              endcase
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              if (to_tx) begin
                phase  <= PH_TX;
                tx_sr  <= rd_data;
                bitcnt <= '0;
              end else if (kind == BK_LO) begin
                phase <= PH_IGNORE;
              end else begin
                phase <= PH_RX;
                kind  <= (kind == BK_DEV) ? BK_HI : BK_LO;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                phase   <= PH_TX_ACK;
                ptr_inc <= 1'b1;
              end else begin
                tx_sr  <= {tx_sr[6:0], 1'b1};
                bitcnt <= bitcnt + 3'd1;
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) begin
              acked <= ~sda_lvl;
            end else if (scl_fall) begin
              if (acked) begin
                phase  <= PH_TX;
                tx_sr  <= rd_data;
                bitcnt <= '0;
              end else begin
                phase <= PH_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // registered pull-down enable: one stage after the phase decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_oe <= 1'b0;
    else        sda_oe <= (phase == PH_RX_ACK) || ((phase == PH_TX) && !tx_sr[7]);
  end

  assign bus_quiet = (phase == PH_IDLE) || (phase == PH_IGNORE);
endmodule

// File: rtl/i2c_byte_mem_slave_chk.sv
module i2c_byte_mem_slave_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_lvl,
  input logic              evt_start,
  input logic              evt_stop,
  input logic              bus_quiet,
  input logic              dev_miss,
  input logic              ptr_load,
  input logic              ptr_inc,
  input logic [ADDR_W-1:0] ptr,
  input logic [ADDR_W-1:0] ptr_load_val
);
  AST_OE_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_lvl || $past(evt_start, 2) || $past(evt_stop, 2))); // R10

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> ##1 !sda_oe); // R2

  AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_quiet |=> !sda_oe); // R9

  AST_MISS_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    dev_miss |=> !sda_oe); // R3

  AST_PTR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> ptr == $past(ptr_load_val)); // R4

  AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_load) |=> ptr == ADDR_W'($past(ptr) + 1'b1)); // R7

  AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_load && (&ptr)) |=> ptr == '0); // R8
endmodule

bind i2c_byte_mem_slave i2c_byte_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
  .evt_start(evt_start), .evt_stop(evt_stop), .bus_quiet(bus_quiet),
  .dev_miss(dev_miss), .ptr_load(ptr_load), .ptr_inc(ptr_inc),
  .ptr(ptr), .ptr_load_val(ptr_load_val)
);

// File: tb/i2c_byte_mem_slave_test.sv
module i2c_byte_mem_slave_test;
  localparam int         AW    = 9;
  localparam int         DEPTH = 1 << AW;
  localparam logic [6:0] DEV   = 7'h57;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  wire bus_sda = sda_m & ~sda_oe;

  i2c_byte_mem_slave #(.ADDR_W(AW), .DEV_ADDR(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_tests = 0, n_fail = 0, exp_ptr = 0, r10_bad = 0;
  logic [7:0] model [DEPTH];
  logic prev_oe = 1'b0;
  bit finished = 1'b0;

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 29) ^ (a >> 3) ^ 8'hA5);
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // R10 monitor: pull-down may only move while the master holds SCL low
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) r10_bad++;
    prev_oe = sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCL period, master drives b, returns line level at mid-high
  task automatic clk_bit(input logic b, output logic seen);
    wait_clk(2); sda_m = b;
    wait_clk(6); scl_m = 1'b1;
    wait_clk(4); seen = bus_sda;
    wait_clk(4); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(8);
    scl_m = 1'b1; wait_clk(6);
    sda_m = 1'b0; wait_clk(6);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(2); sda_m = 1'b0;
    wait_clk(6); scl_m = 1'b1;
    wait_clk(6); sda_m = 1'b1;
    wait_clk(6);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~master_ack, s);
  endtask

  // dummy write of the word address; upper bits of the high byte are junk (R4)
  task automatic set_ptr(input int a, input bit close);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R3 write-address ack", ack, 1);
    send_byte({7'b1011011, 1'(a >> 8)}, ack); chk("R4 high word ack", ack, 1);
    send_byte(8'(a), ack); chk("R4 low word ack", ack, 1);
    exp_ptr = a % DEPTH;
    if (close) bus_stop();
  endtask

  task automatic read_run(input string rq, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("R6 read-address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(rq, d, model[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % DEPTH;
    end
    bus_stop();
  endtask

  initial begin
    logic ack, s;
    logic [7:0] d;
    wait_clk(3);
    chk("R1 reset pull-down", sda_oe, 0);
    rst_n = 1'b1;
    wait_clk(2);
    // fill through the side port (R11)
    for (int a = 0; a < DEPTH; a++) begin
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = pattern(a);
      model[a] = pattern(a);
      wait_clk(1);
    end
    wr_en = 1'b0;
    wait_clk(4);

    // R1: pointer starts at 0
    read_run("R1 first current read", 1);

    // R6 random reads over a stride of the array, high byte bit 8 included
    for (int a = 3; a < DEPTH; a += 37) begin
      set_ptr(a, 1'b0);
      read_run("R6 random read data", 1);
    end

    // R5 pointer-only transaction, then current read; R9 rests one past
    set_ptr(300, 1'b1);
    read_run("R5 current read after set", 1);
    read_run("R9 pointer after nack", 1);

    // R7 R8 sequential across the end of the array
    set_ptr(509, 1'b0);
    read_run("R8 wrap sequential", 6);

    // R7 full sweep of the array plus wrap
    set_ptr(200, 1'b1);
    read_run("R7 sequential sweep", DEPTH + 2);

    // R3 mismatch: no ack, following bytes ignored, pointer kept
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ack); chk("R3 mismatch no ack", ack, 0);
    send_byte(8'h00, ack); chk("R3 ignored byte no ack", ack, 0);
    send_byte(8'h05, ack); chk("R3 ignored byte no ack", ack, 0);
    bus_stop();
    read_run("R3 pointer kept after mismatch", 1);

    // R9 after nack, extra clocks see a released line
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("R6 read-address ack", ack, 1);
    recv_byte(1'b0, d); chk("R9 data before nack", d, model[exp_ptr]);
    exp_ptr = (exp_ptr + 1) % DEPTH;
    begin
      int lows = 0;
      for (int i = 0; i < 18; i++) begin
        clk_bit(1'b1, s);
        if (!s) lows++;
      end
      chk("R9 line released after nack", lows, 0);
    end
    bus_stop();
    read_run("R9 pointer after idle clocks", 1);

    // R2 repeated start in mid-byte restarts reception
    bus_start();
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    read_run("R2 read after mid-byte restart", 1);

    // R11 overwrite one location and read it back
    wr_en = 1'b1; wr_addr = AW'(77); wr_data = 8'h3C; model[77] = 8'h3C;
    wait_clk(1);
    wr_en = 1'b0;
    set_ptr(77, 1'b0);
    read_run("R11 side-port write visible", 1);

    chk("R10 pull-down moves only with SCL low", r10_bad, 0);
    wait_clk(10);
    finish_run();
  end
endmodule